// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block takes one warp-wide access to a word-addressed scratchpad of 32 banks and turns it into a schedule of conflict-free passes. Each of the 32 lanes brings an active bit and a word address. The bank a lane targets is given by the low address bits, which is the address modulo the bank count. When two active lanes need different words in the same bank, they cannot be served in the same cycle. The block replays the request until every active lane has been served. Lanes that ask for the same word are merged into one bank access.

In each pass, every bank takes the address of its lowest-indexed active lane that has not yet been served. All unserved lanes that hold exactly that address are served with it. Per pass, the block drives per-bank enables and addresses and a mask of the lanes served in that cycle. On the final pass it raises a last flag and reports the conflict degree, which is the largest number of distinct addresses that any one bank had to take. The SRAM and the return of data sit outside the block.

Control is a two-state machine. `ST_IDLE` holds `req_ready` high. `ST_IDLE -> ST_ISSUE` is taken when `req_valid` and `req_ready` are both high; the request is captured at that edge. `ST_ISSUE -> ST_ISSUE` is taken while unserved active lanes remain after the current pass. `ST_ISSUE -> ST_IDLE` is taken on the pass that serves the last of them, and also on the single pass of a request with no active lanes.

Top module: `bank_conflict_serializer`

## Requirements
- R1: A lane's bank is bits [4:0] of its word address. In each pass, an enabled bank carries exactly one address, taken from a lane served in that pass, and a disabled bank reads address zero.
- R2: A request whose active lanes all fall in different banks completes in one pass. That pass serves every active lane and reports degree 1.
- R3: The number of passes equals the largest count of distinct addresses among the active lanes of any single bank. Stride-2 word addressing across 32 lanes gives 2 passes, and stride-32 addressing gives 32.
- R4: Active lanes with identical addresses are served in the same pass and add nothing to the degree. Thirty-two lanes reading one word complete in one pass.
- R5: In each pass, each bank serves the address of its lowest-indexed unserved active lane, together with every unserved active lane that holds that same address.
- R6: Inactive lanes are never served, and their addresses have no effect on the schedule or on the bank outputs.
- R7: A request with no active lanes produces exactly one pass with `pass_valid` high, an all-zero served mask, no bank enabled, `pass_last` high and degree 0.
- R8: `req_ready` is high only in idle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. The first pass appears in the cycle after acceptance. `req_ready` stays low through the last pass and returns high in the cycle after it. Input changes while `req_ready` is low have no effect.
- R9: `pass_last` is high only on the final pass of a request, and `conflict_degree` then carries the degree; at all other times `conflict_degree` is zero.
- R10: Each active lane is served in exactly one pass of its request.
- R11: A column walk of a 32-by-33 padded array (word address 33×lane) completes in one pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and can accept a request |
| req_active | input | LANES | Per-lane active bit |
| req_addr | input | LANES*AW | Per-lane word address; lane i occupies bits [i*AW +: AW] |
| pass_valid | output | 1 | A pass is being issued this cycle |
| bank_en | output | BANKS | Per-bank access enable for this pass |
| bank_addr | output | BANKS*AW | Per-bank word address; bank b occupies bits [b*AW +: AW] |
| lane_served | output | LANES | Lanes completed by this pass |
| pass_last | output | 1 | Final pass of the current request |
| conflict_degree | output | $clog2(LANES+1) | Degree of the request, valid while pass_last is high |

## Verification
A corrupted pending mask shows up at the ports in the very next pass. It appears either as a lane served for a second time, as a bank enabled for an address that no remaining lane holds, or as a pass count that differs from the per-bank distinct-address count. A wrong leader choice changes `bank_addr` and `lane_served` in the same cycle in which it happens. A state register stuck in issue keeps `req_ready` low one cycle past `pass_last`. For these reasons the bench compares every output, in every cycle of every request, against a lane-by-lane model, and checks the degree against a distinct-address count made separately.

// File: rtl/scs_pkg.sv
package scs_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } scs_state_e;

endpackage

// File: rtl/scs_pair_matrix.sv
// Pairwise lane relations over the held request addresses.
// Row i, column j: bit i*LANES+j compares lane i against lane j.
module scs_pair_matrix #(
    parameter int unsigned LANES = 32,
    parameter int unsigned AW    = 32,
    parameter int unsigned BB    = 5
) (
    input  logic [LANES*AW-1:0]    addr_flat,
    output logic [LANES*LANES-1:0] same_bank,
    output logic [LANES*LANES-1:0] same_word
);

    for (genvar gi = 0; gi < LANES; gi++) begin : g_row
        for (genvar gj = 0; gj < LANES; gj++) begin : g_col
            assign same_word[gi*LANES+gj] =
                (addr_flat[gi*AW +: AW] == addr_flat[gj*AW +: AW]);
            assign same_bank[gi*LANES+gj] =
                (addr_flat[gi*AW +: BB] == addr_flat[gj*AW +: BB]);
        end
    end

endmodule

// File: rtl/scs_pass_pick.sv
// Picks, per bank, the lowest pending lane (leader) and the lanes that
// share the leader's word this pass.
module scs_pass_pick #(
    parameter int unsigned LANES = 32
) (
    input  logic [LANES-1:0]       pend,
    input  logic [LANES*LANES-1:0] same_bank,
    input  logic [LANES*LANES-1:0] same_word,
    output logic [LANES-1:0]       leader,
    output logic [LANES-1:0]       served
);

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        localparam logic [LANES-1:0] LOWER = (LANES'(1) << gi) - LANES'(1);
        logic blocked;
        assign blocked    = |(pend & same_bank[gi*LANES +: LANES] & LOWER);
        assign leader[gi] = pend[gi] & ~blocked;
        assign served[gi] = pend[gi] & |(leader & same_word[gi*LANES +: LANES]);
    end

endmodule

// File: rtl/scs_bank_route.sv
// Routes each leader's address onto the bank it selects.
module scs_bank_route #(
    parameter int unsigned LANES = 32,
    parameter int unsigned BANKS = 32,
    parameter int unsigned AW    = 32,
    parameter int unsigned BB    = 5
) (
    input  logic [LANES*AW-1:0] addr_flat,
    input  logic [LANES-1:0]    leader,
    output logic [BANKS-1:0]    bank_en,
    output logic [BANKS*AW-1:0] bank_addr
);

    for (genvar gb = 0; gb < BANKS; gb++) begin : g_bank
        logic [LANES-1:0] hit;
        logic [AW-1:0]    word;
        always_comb begin
            hit  = '0;
            word = '0;
            for (int i = 0; i < LANES; i++) begin
                hit[i] = leader[i] && (addr_flat[i*AW +: BB] == BB'(gb));
                if (hit[i]) begin
                    word = word | addr_flat[i*AW +: AW];
                end
            end
        end
        assign bank_en[gb]              = |hit;
        assign bank_addr[gb*AW +: AW]   = word;
    end

endmodule

// File: rtl/bank_conflict_serializer.sv
module bank_conflict_serializer
    import scs_pkg::*;
#(
    parameter int unsigned LANES = 32,
    parameter int unsigned BANKS = 32,
    parameter int unsigned AW    = 32,
    localparam int unsigned DW   = $clog2(LANES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [LANES-1:0]    req_active,
    input  logic [LANES*AW-1:0] req_addr,
    output logic                pass_valid,
    output logic [BANKS-1:0]    bank_en,
    output logic [BANKS*AW-1:0] bank_addr,
    output logic [LANES-1:0]    lane_served,
    output logic                pass_last,
    output logic [DW-1:0]       conflict_degree
);

    localparam int unsigned BB = $clog2(BANKS);

    scs_state_e state_q, state_d;

    logic [LANES*AW-1:0]    addr_q;
    logic [LANES-1:0]       pend_q;
    logic [DW-1:0]          pass_cnt_q;
    logic                   any_q;
    logic                   accept;
    logic [LANES*LANES-1:0] same_bank;
    logic [LANES*LANES-1:0] same_word;
    logic [LANES-1:0]       leader;
    logic [LANES-1:0]       served;
    logic [LANES-1:0]       remaining;
    logic [BANKS-1:0]       route_en;
    logic [BANKS*AW-1:0]    route_addr;

    scs_pair_matrix #(.LANES(LANES), .AW(AW), .BB(BB)) pair_i (
        .addr_flat (addr_q),
        .same_bank (same_bank),
        .same_word (same_word)
    );

    scs_pass_pick #(.LANES(LANES)) pick_i (
        .pend      (pend_q),
        .same_bank (same_bank),
        .same_word (same_word),
        .leader    (leader),
        .served    (served)
    );

    scs_bank_route #(.LANES(LANES), .BANKS(BANKS), .AW(AW), .BB(BB)) route_i (
        .addr_flat (addr_q),
        .leader    (leader),
        .bank_en   (route_en),
        .bank_addr (route_addr)
    );

    assign remaining = pend_q & ~served;
    assign accept    = req_valid & req_ready;

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept)            state_d = ST_ISSUE;
            ST_ISSUE: if (remaining == '0)   state_d = ST_IDLE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request hold, pending lanes and pass counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q     <= '0;
            pend_q     <= '0;
            pass_cnt_q <= '0;
            any_q      <= 1'b0;
        end else if (accept) begin
            addr_q     <= req_addr;
            pend_q     <= req_active;
            pass_cnt_q <= '0;
            any_q      <= |req_active;
        end else if (state_q == ST_ISSUE) begin
            pend_q     <= remaining;
            pass_cnt_q <= pass_cnt_q + DW'(1);
        end
    end

    // Outputs
    always_comb begin
        req_ready       = 1'b0;
        pass_valid      = 1'b0;
        bank_en         = '0;
        bank_addr       = '0;
        lane_served     = '0;
        pass_last       = 1'b0;
        conflict_degree = '0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_ISSUE: begin
                pass_valid  = 1'b1;
                bank_en     = route_en;
                bank_addr   = route_addr;
                lane_served = served;
                pass_last   = (remaining == '0);
                if (pass_last && any_q) begin
                    conflict_degree = pass_cnt_q + DW'(1);
                end
            end
            default: begin
                req_ready = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/scs_serializer_chk.sv
module scs_serializer_chk #(
    parameter int unsigned LANES = 32,
    parameter int unsigned BANKS = 32,
    localparam int unsigned DW   = $clog2(LANES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             pass_valid,
    input logic             pass_last,
    input logic [BANKS-1:0] bank_en,
    input logic [LANES-1:0] lane_served,
    input logic [LANES-1:0] pend_q,
    input logic [DW-1:0]    conflict_degree
);

    logic [DW:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      run_cnt <= '0;
        else if (req_valid && req_ready) run_cnt <= '0;
        else if (pass_valid)             run_cnt <= run_cnt + (DW+1)'(1);
    end

    p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pass_valid |-> !req_ready);

    p_accept_then_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> pass_valid);

    p_last_returns_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pass_last |=> (!pass_valid && req_ready));

    p_last_only_in_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pass_last |-> pass_valid);

    p_keeps_issuing_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_valid && !pass_last) |=> pass_valid);

    p_served_is_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pass_valid |-> ((lane_served & ~pend_q) == '0));

    p_served_retired_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_valid && !pass_last) |=> ((pend_q & $past(lane_served)) == '0));

    p_progress_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_valid && pend_q != '0) |-> (lane_served != '0));

    p_banks_le_lanes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pass_valid |-> ($countones(bank_en) <= $countones(lane_served)));

    p_pass_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pass_valid |-> (run_cnt < (DW+1)'(LANES)));

    p_degree_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_last && pend_q != '0) |-> ({1'b0, conflict_degree} == run_cnt + (DW+1)'(1)));

    p_empty_request_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_valid && pend_q == '0) |-> (pass_last && bank_en == '0 && conflict_degree == '0));

endmodule

bind bank_conflict_serializer scs_serializer_chk #(.LANES(LANES), .BANKS(BANKS)) chk_i (.*);

// File: tb/bank_conflict_serializer_tb.sv
module bank_conflict_serializer_tb_top;

    localparam int L  = 32;
    localparam int B  = 32;
    localparam int AW = 32;
    localparam int DW = $clog2(L + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [L-1:0]    req_active = '0;
    logic [L*AW-1:0] req_addr = '0;
    logic            pass_valid;
    logic [B-1:0]    bank_en;
    logic [B*AW-1:0] bank_addr;
    logic [L-1:0]    lane_served;
    logic            pass_last;
    logic [DW-1:0]   conflict_degree;

    int vectors = 0;
    int miscompares = 0;

    logic [31:0] st_addr [L];
    logic [L-1:0] st_act;

    always #10 clk = ~clk;

    bank_conflict_serializer #(.LANES(L), .BANKS(B), .AW(AW)) dut_i (.*);

    task automatic mis(string rq, string what, longint unsigned act, longint unsigned exp);
        miscompares++;
        $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    endtask

    task automatic check_idle(string rq);
        vectors++;
        if (!req_ready)      mis(rq, "req_ready in idle", req_ready, 1);
        if (pass_valid)      mis(rq, "pass_valid in idle", pass_valid, 0);
        if (bank_en != '0)   mis(rq, "bank_en in idle", bank_en, 0);
    endtask

    // Drive one request from st_addr/st_act and follow it to completion.
    task automatic run_req(string rq, bit hold);
        logic [L-1:0] pend, exp_srv, acc;
        logic [B-1:0] exp_en;
        logic [31:0]  exp_ba [B];
        logic [31:0]  seen [$];
        int           lead [B];
        int           exp_deg, passes, b, found;
        bit           done, exp_last;

        // independent degree: distinct active addresses per bank
        exp_deg = 0;
        for (int bb = 0; bb < B; bb++) begin
            seen.delete();
            for (int i = 0; i < L; i++) begin
                if (st_act[i] && (st_addr[i] % B) == bb) begin
                    found = 0;
                    foreach (seen[k]) if (seen[k] == st_addr[i]) found = 1;
                    if (found == 0) seen.push_back(st_addr[i]);
                end
            end
            if (seen.size() > exp_deg) exp_deg = seen.size();
        end

        @(negedge clk);
        check_idle(rq);
        req_valid  = 1'b1;
        req_active = st_act;
        for (int i = 0; i < L; i++) req_addr[i*AW +: AW] = st_addr[i];
        pend = st_act;
        acc = '0;
        passes = 0;
        done = 0;
        @(negedge clk);
        // scramble inputs after capture: they must not matter (R8)
        if (!hold) req_valid = 1'b0;
        req_active = ~st_act;
        for (int i = 0; i < L; i++) req_addr[i*AW +: AW] = st_addr[i] ^ 32'h0000_0021;

        while (!done) begin
            for (int bb = 0; bb < B; bb++) lead[bb] = -1;
            for (int i = 0; i < L; i++) begin
                b = st_addr[i] % B;
                if (pend[i] && lead[b] < 0) lead[b] = i;
            end
            exp_en = '0;
            for (int bb = 0; bb < B; bb++) begin
                exp_en[bb] = (lead[bb] >= 0);
                exp_ba[bb] = (lead[bb] >= 0) ? st_addr[lead[bb]] : 32'h0;
            end
            exp_srv = '0;
            for (int i = 0; i < L; i++) begin
                b = st_addr[i] % B;
                if (pend[i] && lead[b] >= 0 && st_addr[lead[b]] == st_addr[i]) exp_srv[i] = 1'b1;
            end
            exp_last = ((pend & ~exp_srv) == '0);

            vectors++;
            if (!pass_valid)              mis("R8", "pass_valid during request", pass_valid, 1);
            if (req_ready)                mis("R8", "req_ready during request", req_ready, 0);
            if (bank_en != exp_en)        mis("R1", {rq, " bank_en"}, bank_en, exp_en);
            for (int bb = 0; bb < B; bb++)
                if (bank_addr[bb*AW +: AW] != exp_ba[bb])
                    mis("R1", {rq, " bank_addr"}, bank_addr[bb*AW +: AW], exp_ba[bb]);
            if (lane_served != exp_srv)   mis("R5", {rq, " lane_served"}, lane_served, exp_srv);
            if (pass_last != exp_last)    mis("R9", {rq, " pass_last"}, pass_last, exp_last);
            if (exp_last) begin
                if (conflict_degree != DW'(exp_deg))
                    mis("R9", {rq, " conflict_degree"}, conflict_degree, exp_deg);
            end else if (conflict_degree != '0) begin
                mis("R9", {rq, " degree before last"}, conflict_degree, 0);
            end
            if ((acc & lane_served) != '0) mis("R10", {rq, " lane served twice"}, acc & lane_served, 0);
            acc  = acc | lane_served;
            pend = pend & ~exp_srv;
            passes++;
            done = exp_last;
            if (passes > L + 2) begin
                mis("R3", {rq, " runaway passes"}, passes, exp_deg);
                done = 1;
            end
            if (done) req_valid = 1'b0;
            @(negedge clk);
        end

        check_idle("R8");
        vectors++;
        if (passes != ((exp_deg == 0) ? 1 : exp_deg)) mis(rq, "pass count", passes, exp_deg);
        vectors++;
        if (acc != st_act) mis("R10", {rq, " served union"}, acc, st_act);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mis("R8", "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_idle("R8");   // reset state

        // R2: stride 1, every bank once
        st_act = '1;
        for (int i = 0; i < L; i++) st_addr[i] = 32'd64 + i;
        run_req("R2", 0);

        // R3: stride 2 -> two passes
        for (int i = 0; i < L; i++) st_addr[i] = 2 * i;
        run_req("R3", 0);

        // R3: stride 32 -> thirty-two passes, inputs held busy (R8)
        for (int i = 0; i < L; i++) st_addr[i] = 32 * i + 5;
        run_req("R3", 1);

        // R11: padded column walk
        for (int i = 0; i < L; i++) st_addr[i] = 33 * i + 7;
        run_req("R11", 0);

        // R4: full broadcast of one word
        for (int i = 0; i < L; i++) st_addr[i] = 32'h1234;
        run_req("R4", 0);

        // R5: ordering within bank 3, degree 4
        st_act = 32'h0000_00FF;
        st_addr[0] = 3;  st_addr[1] = 35; st_addr[2] = 3;  st_addr[3] = 67;
        st_addr[4] = 35; st_addr[5] = 99; st_addr[6] = 3;  st_addr[7] = 67;
        for (int i = 8; i < L; i++) st_addr[i] = 32 * i;
        run_req("R5", 0);

        // R6: odd lanes inactive with conflicting addresses
        st_act = 32'h5555_5555;
        for (int i = 0; i < L; i++) st_addr[i] = 32 * i + ((i % 2) ? 32'd1000 : 32'd0);
        run_req("R6", 0);

        // R7: empty request
        st_act = '0;
        run_req("R7", 0);

        // mixed patterns with small address range for conflicts and merges
        for (int n = 0; n < 24; n++) begin
            st_act = $urandom;
            for (int i = 0; i < L; i++) st_addr[i] = $urandom_range(0, 127);
            run_req("R3", n % 2);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule